// File: doc/BRIEF.md
# Multi-Width Adder Status Flag Unit

This unit adds or subtracts two operands at one of three widths (byte, half-word or word) and produces the result together with six status flags: carry, parity, auxiliary carry, zero, sign and overflow. Both operands share one adder, and an extra carry or borrow input allows chained multi-word arithmetic. A size code selects which bit is treated as the most significant. The carry, sign and overflow flags follow that bit. The parity flag always looks at the low byte, and the auxiliary carry always looks at the boundary between bits 3 and 4.

The datapath is combinational. A parameter can add one register stage at the outputs to ease timing. With the default setting, all outputs appear one clock after the inputs are presented, and reset clears them to zero. The unit has no states or transitions: it is a pure pipeline, and the only storage is the optional output stage.

Top module: `alu_flag_gen`

## Requirements
- R1: `size_i` selects the operand width: 2'b00 is 8-bit, 2'b01 is 16-bit, 2'b10 is 32-bit, and 2'b11 is also treated as 32-bit. Operand bits above the selected width are ignored, and the matching result bits are driven to zero.
- R2: With `sub_i`=0, `result_o` equals `op_a_i + op_b_i + carry_i`, truncated to the selected width.
- R3: With `sub_i`=1, `result_o` equals `op_a_i - op_b_i - carry_i`, truncated to the selected width.
- R4: `cf_o` is 1 on an addition whose exact unsigned sum does not fit the selected width, or on a subtraction whose exact unsigned difference is negative (a borrow).
- R5: `pf_o` is 1 when `result_o[7:0]` holds an even number of ones, at every width.
- R6: `af_o` is 1 on a carry out of bit 3 (addition) or a borrow into bit 3 (subtraction), at every width.
- R7: `zf_o` is 1 exactly when the size-masked result is zero.
- R8: `sf_o` equals result bit 7, 15 or 31 for the 8-, 16- and 32-bit widths.
- R9: `of_o` is 1 when the exact signed result does not fit the selected width, which is the case when the carry into the sign bit differs from the carry out of it.
- R10: With the default output stage, every output reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low reset for the output stage |
| op_a_i | input | 32 | First operand (minuend when subtracting) |
| op_b_i | input | 32 | Second operand (subtrahend when subtracting) |
| carry_i | input | 1 | Carry-in when adding, borrow-in when subtracting |
| sub_i | input | 1 | 0 selects addition, 1 selects subtraction |
| size_i | input | 2 | Operand width code |
| result_o | output | 32 | Size-masked result |
| cf_o | output | 1 | Carry / borrow flag |
| pf_o | output | 1 | Even parity of the low result byte |
| af_o | output | 1 | Carry or borrow at the bit 3 / bit 4 boundary |
| zf_o | output | 1 | Masked result is zero |
| sf_o | output | 1 | Sign bit of the masked result |
| of_o | output | 1 | Signed overflow |

## Verification
The clocked assertions compare the adder's masked result, the flag logic's outputs and the registered outputs. They are only meaningful when every input holds a known 0 or 1 on every clock edge outside reset. They also assume that the size code is always one of its four values, with no X bits. The bench drives every input to a defined value before reset is released and changes inputs only on the falling edge. Its random operands use all 32 bits at every size, so the bits above the selected width are exercised without ever leaving the assumed input space.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } opsize_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } flags_t;

endpackage

// File: rtl/alu_size_decode.sv
module alu_size_decode
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DATA_W) + 1
) (
    input  opsize_e             size_i,
    output logic [DATA_W-1:0]   mask_o,
    output logic [IDX_W-1:0]    top_o
);

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    always_comb begin
        unique case (size_i)
            SZ_BYTE: begin
                mask_o = DATA_W'({BYTE_W{1'b1}});
                top_o  = IDX_W'(BYTE_W - 1);
            end
            SZ_HALF: begin
                mask_o = DATA_W'({HALF_W{1'b1}});
                top_o  = IDX_W'(HALF_W - 1);
            end
            SZ_WORD, SZ_WORD_ALT: begin
                mask_o = {DATA_W{1'b1}};
                top_o  = IDX_W'(DATA_W - 1);
            end
            default: begin
                mask_o = {DATA_W{1'b1}};
                top_o  = IDX_W'(DATA_W - 1);
            end
        endcase
    end

endmodule

// File: rtl/alu_add_core.sv
module alu_add_core #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] res_o,
    output logic [DATA_W:0]   carry_o
);

    logic [DATA_W-1:0] b_eff;
    logic              c0;
    logic [DATA_W:0]   sum;

    // Subtraction runs as a + ~b + ~borrow_in.
    assign b_eff = sub_i ? ~b_i : b_i;
    assign c0    = sub_i ? ~cin_i : cin_i;
    assign sum   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c0};

    // carry_o[i] is the carry into bit i; carry_o[DATA_W] is the carry out of the top bit.
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_carry
            assign carry_o[gi] = sum[gi] ^ a_i[gi] ^ b_eff[gi];
        end
    endgenerate
    assign carry_o[DATA_W] = sum[DATA_W];

    assign res_o = sum[DATA_W-1:0] & mask_i;

endmodule

// File: rtl/alu_flag_logic.sv
module alu_flag_logic
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DATA_W) + 1,
    parameter int AUX_B  = 4
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic [DATA_W:0]   carry_i,
    input  logic [IDX_W-1:0]  top_i,
    input  logic              sub_i,
    output flags_t            flags_o
);

    logic c_out_top;
    logic c_into_top;

    assign c_out_top  = carry_i[top_i + IDX_W'(1)];
    assign c_into_top = carry_i[top_i];

    always_comb begin
        flags_o.cf = c_out_top ^ sub_i;
        flags_o.pf = ~(^res_i[7:0]);
        flags_o.af = carry_i[AUX_B] ^ sub_i;
        flags_o.zf = ~(|res_i);
        flags_o.sf = res_i[top_i];
        flags_o.of = c_out_top ^ c_into_top;
    end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_flag_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       op_a_i,
    input  logic [31:0]       op_b_i,
    input  logic              carry_i,
    input  logic              sub_i,
    input  logic [1:0]        size_i,
    output logic [31:0]       result_o,
    output logic              cf_o,
    output logic              pf_o,
    output logic              af_o,
    output logic              zf_o,
    output logic              sf_o,
    output logic              of_o
);

    localparam int IDX_W = $clog2(DATA_W) + 1;

    logic [DATA_W-1:0] mask_c;
    logic [IDX_W-1:0]  top_c;
    logic [DATA_W-1:0] res_c;
    logic [DATA_W:0]   carry_c;
    flags_t            flags_c;
    flags_t            flags_q;
    logic [DATA_W-1:0] res_q;

    alu_size_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_size (
        .size_i (opsize_e'(size_i)),
        .mask_o (mask_c),
        .top_o  (top_c)
    );

    alu_add_core #(.DATA_W(DATA_W)) u_add (
        .a_i     (op_a_i),
        .b_i     (op_b_i),
        .cin_i   (carry_i),
        .sub_i   (sub_i),
        .mask_i  (mask_c),
        .res_o   (res_c),
        .carry_o (carry_c)
    );

    alu_flag_logic #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_flags (
        .res_i   (res_c),
        .carry_i (carry_c),
        .top_i   (top_c),
        .sub_i   (sub_i),
        .flags_o (flags_c)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q   <= '0;
                    flags_q <= '0;
                end else begin
                    res_q   <= res_c;
                    flags_q <= flags_c;
                end
            end

            // R10
            assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (res_q == $past(res_c)) && (flags_q == $past(flags_c)))
            else $error("stage_latency_chk");
        end else begin : g_comb
            assign res_q   = res_c;
            assign flags_q = flags_c;
        end
    endgenerate

    assign result_o = res_q;
    assign cf_o     = flags_q.cf;
    assign pf_o     = flags_q.pf;
    assign af_o     = flags_q.af;
    assign zf_o     = flags_q.zf;
    assign sf_o     = flags_q.sf;
    assign of_o     = flags_q.of;

    // R1
    assert property (@(posedge clk) disable iff (!rst_n)
        (res_c & ~mask_c) == '0)
    else $error("upper_bits_zero_chk");

    // R7
    assert property (@(posedge clk) disable iff (!rst_n)
        flags_c.zf == (res_c == '0))
    else $error("zero_flag_chk");

    // R5
    assert property (@(posedge clk) disable iff (!rst_n)
        flags_c.pf == ($countones(res_c[7:0]) % 2 == 0))
    else $error("parity_low_byte_chk");

    // R8
    assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'b00) |-> (flags_c.sf == res_c[7]))
    else $error("byte_sign_chk");

    // R8
    assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'b01) |-> (flags_c.sf == res_c[15]))
    else $error("half_sign_chk");

    // R4
    assert property (@(posedge clk) disable iff (!rst_n)
        (!sub_i && !carry_i && op_b_i == '0) |-> !flags_c.cf)
    else $error("no_carry_on_zero_addend_chk");

endmodule

// File: tb/alu_flag_gen_tb.sv
module alu_flag_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        cin = 1'b0;
    logic        sub = 1'b0;
    logic [1:0]  size = 2'b00;
    logic [31:0] result_o;
    logic        cf_o, pf_o, af_o, zf_o, sf_o, of_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu_flag_gen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_a_i   (op_a),
        .op_b_i   (op_b),
        .carry_i  (cin),
        .sub_i    (sub),
        .size_i   (size),
        .result_o (result_o),
        .cf_o     (cf_o),
        .pf_o     (pf_o),
        .af_o     (af_o),
        .zf_o     (zf_o),
        .sf_o     (sf_o),
        .of_o     (of_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int width_of(input logic [1:0] s);
        case (s)
            2'b00:   return 8;
            2'b01:   return 16;
            default: return 32;
        endcase
    endfunction

    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic c, input logic s, input logic [1:0] sz);
        int     w;
        longint m, ua, ub, ex, sa, sb, sx, lo, hi, nib, res;
        w  = width_of(sz);
        m  = (longint'(1) << w) - 1;
        ua = longint'(a) & m;
        ub = longint'(b) & m;
        sa = (ua >= (longint'(1) << (w - 1))) ? ua - (longint'(1) << w) : ua;
        sb = (ub >= (longint'(1) << (w - 1))) ? ub - (longint'(1) << w) : ub;
        if (s) begin
            ex  = ua - ub - longint'(c);
            sx  = sa - sb - longint'(c);
            nib = (ua & 15) - (ub & 15) - longint'(c);
        end else begin
            ex  = ua + ub + longint'(c);
            sx  = sa + sb + longint'(c);
            nib = (ua & 15) + (ub & 15) + longint'(c);
        end
        res = ex & m;
        lo  = -(longint'(1) << (w - 1));
        hi  = (longint'(1) << (w - 1)) - 1;
        @(negedge clk);
        op_a = a; op_b = b; cin = c; sub = s; size = sz;
        @(negedge clk);
        // R1 R2 R3: masked result
        check(s ? "R3/R1 result" : "R2/R1 result", longint'(result_o), res);
        check("R4 cf", longint'(cf_o), longint'(ex < 0 || ex > m));
        check("R5 pf", longint'(pf_o), longint'(($countones(res[7:0]) % 2) == 0));
        check("R6 af", longint'(af_o), longint'(nib < 0 || nib > 15));
        check("R7 zf", longint'(zf_o), longint'(res == 0));
        check("R8 sf", longint'(sf_o), (res >> (w - 1)) & 1);
        check("R9 of", longint'(of_o), longint'(sx < lo || sx > hi));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] ra, rb;
        logic [31:0] seed;
        seed = 32'd1234;
        ra = $urandom(seed);
        op_a = 32'hFFFF_FFFF; op_b = 32'h1234_5678; cin = 1'b1; sub = 1'b1;
        repeat (3) @(negedge clk);
        // R10: outputs held at zero during reset
        check("R10 reset result", longint'(result_o), 0);
        check("R10 reset flags", longint'({cf_o, pf_o, af_o, zf_o, sf_o, of_o}), 0);
        rst_n = 1'b1;

        // directed corners
        apply(32'h0000_00FF, 32'h0000_0001, 1'b0, 1'b0, 2'b00); // byte wrap, zero, aux
        apply(32'h0000_007F, 32'h0000_0001, 1'b0, 1'b0, 2'b00); // byte signed overflow
        apply(32'h0000_0000, 32'h0000_0001, 1'b0, 1'b1, 2'b00); // byte borrow
        apply(32'h0000_0080, 32'h0000_0001, 1'b0, 1'b1, 2'b00); // byte sub overflow
        apply(32'hABCD_7FFF, 32'h1234_0001, 1'b0, 1'b0, 2'b01); // half overflow, upper ignored
        apply(32'h0000_FFFF, 32'h0000_FFFF, 1'b1, 1'b0, 2'b01); // half carry-in chain
        apply(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, 2'b10); // word wrap to zero
        apply(32'h8000_0000, 32'h0000_0001, 1'b0, 1'b1, 2'b10); // word sub overflow
        apply(32'h0000_0005, 32'h0000_0005, 1'b1, 1'b1, 2'b11); // code 11 as word, borrow-in
        apply(32'h1234_5600, 32'h0000_0000, 1'b0, 1'b0, 2'b00); // R1 upper bits ignored -> zero
        apply(32'h0000_0010, 32'h0000_0001, 1'b0, 1'b1, 2'b01); // borrow into bit 3

        // random
        for (int i = 0; i < 400; i++) begin
            ra = $urandom;
            rb = $urandom;
            apply(ra, rb, 1'($urandom), 1'($urandom), 2'($urandom));
        end

        // R10: one-cycle latency, output changes only after the clock edge
        @(negedge clk);
        op_a = 32'd3; op_b = 32'd4; cin = 1'b0; sub = 1'b0; size = 2'b10;
        @(negedge clk);
        op_a = 32'd10; op_b = 32'd20;
        #1;
        check("R10 latency", longint'(result_o), 7);
        @(negedge clk);
        check("R10 latency next", longint'(result_o), 30);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule